// File: doc/BRIEF.md
# Register-Controlled I2C Bus Master

This block is an I2C bus master that software runs through five byte-wide registers. A mode register holds an enable bit, a two-bit clock-rate code and a five-bit receive count. Writing the slave-address register starts one complete bus transaction. The block issues START, shifts out the address byte with its direction bit, and checks the slave's acknowledge. On a write it then sends bytes taken from a transmit buffer. On a read it collects a preset number of bytes into a receive buffer. It always finishes with STOP.

Both bus lines are open-drain. The block only pulls SCL or SDA low through an output-enable, or it lets them go. It samples the real line levels on its inputs, so a slave can stretch the clock by holding SCL low during a high phase.

During a write, the master may run out of data because software has not loaded the next byte. In that case the master parks with SCL held low. It goes on when the buffer is loaded, or it closes the transfer when software posts a stop request. A missing acknowledge to the address or to a data byte aborts the transfer with STOP and raises an error flag.

Top module: `i2c_reg_master`

## Requirements
- R1: Each SCL bit lasts 16·2^N core cycles, half low and half high, where N is mode bits [6:5]. The rate is captured when the transfer starts.
- R2: Mode bit 7 enables the block. While it is 0, an address write starts nothing. Clearing it during a transfer returns the block to idle, with both lines released, within two cycles.
- R3: Register map: 0 = mode, 1 = slave address, 2 = transmit buffer, 3 = receive buffer, 4 = status. A write to register 1 while enabled and idle produces START and then the address byte {addr[7:1], dir[0]} on the bus, MSB first.
- R4: With dir = 0, each data byte comes from the transmit buffer and is sent MSB first after the previous acknowledge. Status bit 3 (transmit empty) is 1 whenever the buffer has been taken, and after reset.
- R5: If the transmit buffer is empty when a write byte is due, SCL stays pulled low and the block stays busy. Writing 1 to status bit 5 then ends the transfer with STOP.
- R6: With dir = 1, exactly mode[4:0]+1 bytes are received. Each byte is readable in register 3. Status bit 4 (receive valid) is set per byte and cleared by reading register 3.
- R7: On a read, the master acknowledges every received byte except the last, which it NACKs before STOP.
- R8: A NACK to the address or to a write byte sets status bit 2, sends no further data, and ends with STOP.
- R9: Status bit 0 is busy. Bit 1 is set when STOP completes. Writing 1 to bit 1 or bit 2 clears that flag. After reset the status reads 0x08.
- R10: While SCL is released during a data bit, SDA holds steady. Both lines are released whenever the block is idle.
- R11: A write to the address register while a transfer is running is ignored: no second START occurs and the stored address is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read side effect on register 3) |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| scl_in | input | 1 | Sensed SCL line level |
| sda_in | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
Register writes take effect on the next clock edge. SCL follows the state register, so the first low phase starts the cycle after the START phase of half a bit period. SDA is registered and trails each SCL fall by one cycle. The bus bit period is measured between successive SCL pull-downs, and compared against 16 or 64 core cycles. An abort is checked two cycles after the enable is cleared. Status flags, bus bytes and master acknowledges come after many bus bits, so the bench polls status until the awaited bit appears, with a cap. A slave model hands each byte it receives to a scoreboard in the order it was queued.

// File: rtl/i2c_reg_master.sv
`timescale 1ns/1ps
module i2c_reg_master #(
  parameter int DIV_BASE_LOG2 = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_oe,
  output logic       sda_oe
);
  typedef enum logic [2:0] {S_IDLE, S_START, S_LO, S_HI, S_HOLD, S_STOP_A, S_STOP_B, S_STOP_C} state_t;
  localparam logic [2:0] A_MODE = 3'd0, A_SLV = 3'd1, A_TX = 3'd2, A_RX = 3'd3, A_STAT = 3'd4;
  localparam int CW = DIV_BASE_LOG2 + 4;

  state_t st;
  logic en, txe, rxv, done, nackf, stopreq, is_rd, in_addr, sda_q, sda_want;
  logic [1:0] rate, rate_q;
  logic [4:0] rcount, rleft;
  logic [7:0] slv, txbuf, rxbuf, shreg;
  logic [3:0] bitc;
  logic [CW-1:0] cnt, half_m1;
  logic is_idle, is_hi, is_hold, adv, tick, start_go, tx_phase;
  logic wr_mode, wr_slv, wr_tx, wr_stat, rd_rx;

  assign wr_mode  = reg_wr && reg_addr == A_MODE;
  assign wr_slv   = reg_wr && reg_addr == A_SLV;
  assign wr_tx    = reg_wr && reg_addr == A_TX;
  assign wr_stat  = reg_wr && reg_addr == A_STAT;
  assign rd_rx    = reg_rd && reg_addr == A_RX;

  assign is_idle  = st == S_IDLE;
  assign is_hi    = st == S_HI;
  assign is_hold  = st == S_HOLD;
  assign start_go = wr_slv && is_idle && en;
  assign tx_phase = in_addr || !is_rd;

  assign half_m1  = CW'((32'd1 << (DIV_BASE_LOG2 + int'(rate_q))) - 32'd1);
  assign adv      = !(is_hi && !scl_in);
  assign tick     = adv && cnt == half_m1;

  assign scl_oe   = st == S_LO || st == S_HOLD || st == S_STOP_A;
  assign sda_oe   = sda_q;

  always_comb begin
    case (st)
      S_START, S_STOP_A, S_STOP_B: sda_want = 1'b1;
      S_LO:    sda_want = bitc[3] ? (!tx_phase && rleft != 5'd0) : (tx_phase && !shreg[7]);
      S_HI:    sda_want = sda_q;
      default: sda_want = 1'b0;
    endcase
  end

  always_comb begin
    case (reg_addr)
      A_MODE:  reg_rdata = {en, rate, rcount};
      A_SLV:   reg_rdata = slv;
      A_TX:    reg_rdata = txbuf;
      A_RX:    reg_rdata = rxbuf;
      A_STAT:  reg_rdata = {2'b00, stopreq, rxv, txe, nackf, done, !is_idle};
      default: reg_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (is_idle || is_hold || tick) cnt <= '0;
    else if (adv) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      {en, rate, rcount} <= 8'h00;
      {slv, txbuf, rxbuf, shreg} <= '0;
      rate_q <= 2'd0;
      rleft <= 5'd0;
      bitc <= 4'd0;
      txe <= 1'b1;
      {rxv, done, nackf, stopreq, is_rd, in_addr, sda_q} <= '0;
    end else begin
      sda_q <= en && sda_want;
      if (wr_mode) {en, rate, rcount} <= reg_wdata;
      if (wr_slv && is_idle) slv <= reg_wdata;
      if (wr_stat) begin
        if (reg_wdata[1]) done <= 1'b0;
        if (reg_wdata[2]) nackf <= 1'b0;
        if (reg_wdata[5] && !is_idle) stopreq <= 1'b1;
      end
      if (rd_rx) rxv <= 1'b0;
      if (!en) begin
        st <= S_IDLE;
        stopreq <= 1'b0;
      end else begin
        case (st)
          S_IDLE: if (start_go) begin
            st <= S_START;
            shreg <= reg_wdata;
            is_rd <= reg_wdata[0];
            in_addr <= 1'b1;
            rate_q <= rate;
            rleft <= rcount;
            stopreq <= 1'b0;
            bitc <= 4'd0;
          end
          S_START: if (tick) begin
            st <= S_LO;
            bitc <= 4'd0;
          end
          S_LO: if (tick) st <= S_HI;
          S_HI: if (tick) begin
            if (!bitc[3]) begin
              shreg <= {shreg[6:0], sda_in};
              bitc <= bitc + 4'd1;
              st <= S_LO;
              if (bitc == 4'd7 && !tx_phase) begin
                rxbuf <= {shreg[6:0], sda_in};
                rxv <= 1'b1;
              end
            end else if (tx_phase) begin
              in_addr <= 1'b0;
              if (sda_in) begin
                nackf <= 1'b1;
                st <= S_STOP_A;
              end else if (is_rd) begin
                bitc <= 4'd0;
                st <= S_LO;
              end else if (!txe) begin
                shreg <= txbuf;
                txe <= 1'b1;
                bitc <= 4'd0;
                st <= S_LO;
              end else if (stopreq) begin
                stopreq <= 1'b0;
                st <= S_STOP_A;
              end else st <= S_HOLD;
            end else if (rleft == 5'd0) st <= S_STOP_A;
            else begin
              rleft <= rleft - 5'd1;
              bitc <= 4'd0;
              st <= S_LO;
            end
          end
          S_HOLD: if (!txe) begin
            shreg <= txbuf;
            txe <= 1'b1;
            bitc <= 4'd0;
            st <= S_LO;
          end else if (stopreq) begin
            stopreq <= 1'b0;
            st <= S_STOP_A;
          end
          S_STOP_A: if (tick) st <= S_STOP_B;
          S_STOP_B: if (tick) st <= S_STOP_C;
          S_STOP_C: if (tick) begin
            st <= S_IDLE;
            done <= 1'b1;
            stopreq <= 1'b0;
          end
          default: st <= S_IDLE;
        endcase
      end
      if (wr_tx) begin
        txbuf <= reg_wdata;
        txe <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/i2c_reg_master_chk.sv
`timescale 1ns/1ps
module i2c_reg_master_chk #(
  parameter int CW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          is_idle,
  input logic          is_hi,
  input logic          start_go,
  input logic          scl_oe,
  input logic          sda_oe,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] half_m1
);
  a_r1_half_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= half_m1);

  a_r2_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> is_idle);

  a_r3_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start_go |=> !is_idle);

  a_r10_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (is_idle && $past(is_idle)) |-> (!scl_oe && !sda_oe));

  a_r10_sda_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    (is_hi && $past(is_hi)) |-> $stable(sda_oe));
endmodule

bind i2c_reg_master i2c_reg_master_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .is_idle(is_idle), .is_hi(is_hi),
  .start_go(start_go), .scl_oe(scl_oe), .sda_oe(sda_oe), .cnt(cnt), .half_m1(half_m1)
);

// File: tb/i2c_reg_master_test.sv
`timescale 1ns/1ps
module i2c_reg_master_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'h00;
  wire  [7:0] reg_rdata;
  wire scl_oe, sda_oe;
  logic s_pull = 1'b0;
  wire scl_l = ~scl_oe;
  wire sda_l = ~(sda_oe | s_pull);

  i2c_reg_master uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_in(scl_l), .sda_in(sda_l),
    .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // scoreboard: expected bytes seen by the slave on the bus
  logic [7:0] exp_q[$];
  task automatic expect_byte(input logic [7:0] b);
    exp_q.push_back(b);
  endtask
  task automatic sb_pop(input logic [7:0] b);
    if (exp_q.size() == 0) chk("R3 unexpected bus byte", b, 'h100);
    else chk("R3/R4 bus byte", b, exp_q.pop_front());
  endtask

  // slave model
  localparam logic [6:0] SLV = 7'h50;
  int bitc = 0, starts = 0;
  logic [7:0] sh = 8'h00, cur = 8'hFF;
  bit in_frame = 0, phase_addr = 0, reading = 0, drv = 0;
  logic [7:0] rd_q[$];
  logic mack_log[$];

  always @(negedge sda_l) if (scl_l === 1'b1) begin
    in_frame = 1; bitc = 0; phase_addr = 1; reading = 0; drv = 0; starts++;
  end
  always @(posedge sda_l) if (scl_l === 1'b1) in_frame = 0;
  always @(posedge scl_l) if (in_frame) begin
    if (bitc < 8) begin
      sh = {sh[6:0], sda_l};
      bitc++;
      if (bitc == 8 && !reading) sb_pop(sh);
    end else begin
      if (phase_addr) begin
        phase_addr = 0;
        reading = (sh[7:1] == SLV) && sh[0];
        drv = reading;
      end else if (reading) begin
        mack_log.push_back(sda_l);
        if (sda_l) drv = 0;
      end
      bitc = 0;
    end
  end
  always @(negedge scl_l) if (in_frame) begin
    if (bitc == 8) s_pull = phase_addr ? (sh[7:1] == SLV) : !reading;
    else if (reading && drv) begin
      if (bitc == 0) cur = (rd_q.size() > 0) ? rd_q.pop_front() : 8'hFF;
      s_pull = ~cur[7-bitc];
    end else s_pull = 1'b0;
  end

  task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask
  task automatic reg_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask
  task automatic wait_status(input int bitn, input logic val, input string tag);
    logic [7:0] s;
    int n = 0;
    do begin reg_read(3'd4, s); n++; end while (s[bitn] !== val && n < 20000);
    if (s[bitn] !== val) chk(tag, s[bitn], val);
  endtask
  task automatic report;
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 180000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R9 watchdog act=running exp=idle");
      report();
    end
  end

  initial begin
    logic [7:0] s;
    logic [7:0] exp_rd [3] = '{8'h11, 8'h22, 8'h33};
    realtime t0;
    int st0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    reg_read(3'd4, s); chk("R9 reset status", s, 8'h08);
    reg_read(3'd0, s); chk("R2 reset mode", s, 8'h00);
    chk("R10 reset scl", scl_oe, 0);
    chk("R10 reset sda", sda_oe, 0);

    // R2: disabled, address write ignored
    reg_write(3'd1, 8'hA0);
    repeat (100) @(negedge clk);
    reg_read(3'd4, s); chk("R2 disabled no busy", s, 8'h08);
    chk("R2 disabled no start", starts, 0);

    // R1 R3 R4 R5: write at rate 0 with hold and stop request
    reg_write(3'd0, 8'h80);
    expect_byte(8'hA0); expect_byte(8'hA5);
    reg_write(3'd2, 8'hA5);
    reg_write(3'd1, 8'hA0);
    @(posedge scl_oe); t0 = $realtime;
    @(posedge scl_oe); chk("R1 period rate0", int'(($realtime - t0) / 20.0), 16);
    wait_status(3, 1'b1, "R4 txe after load");
    expect_byte(8'h3C);
    reg_write(3'd2, 8'h3C);
    wait_status(3, 1'b1, "R4 txe second");
    repeat (400) @(negedge clk);
    chk("R5 hold scl low", scl_oe, 1);
    reg_read(3'd4, s); chk("R5 busy in hold", s[0], 1);
    repeat (100) @(negedge clk);
    chk("R5 hold scl still low", scl_oe, 1);
    reg_write(3'd4, 8'h20);
    wait_status(0, 1'b0, "R5 stop request ends");
    reg_read(3'd4, s); chk("R9 done after write", s, 8'h0A);
    chk("R4 scoreboard drained", exp_q.size(), 0);
    chk("R10 idle scl", scl_oe, 0);
    chk("R10 idle sda", sda_oe, 0);
    reg_write(3'd4, 8'h02);
    reg_read(3'd4, s); chk("R9 done w1c", s, 8'h08);

    // R1 at rate 2
    reg_write(3'd0, 8'hC0);
    expect_byte(8'hA0);
    reg_write(3'd1, 8'hA0);
    @(posedge scl_oe); t0 = $realtime;
    @(posedge scl_oe); chk("R1 period rate2", int'(($realtime - t0) / 20.0), 64);
    reg_write(3'd4, 8'h20);
    wait_status(0, 1'b0, "R5 stop at rate2");
    reg_read(3'd4, s); chk("R9 done rate2", s, 8'h0A);
    reg_write(3'd4, 8'h02);

    // R6 R7 R11: read three bytes, address write while busy
    reg_write(3'd0, 8'h82);
    rd_q.push_back(8'h11); rd_q.push_back(8'h22); rd_q.push_back(8'h33);
    expect_byte(8'hA1);
    mack_log.delete();
    st0 = starts;
    reg_write(3'd1, 8'hA1);
    reg_write(3'd1, 8'h44);
    for (int i = 0; i < 3; i++) begin
      wait_status(4, 1'b1, "R6 rx valid");
      reg_read(3'd3, s); chk("R6 rx byte", s, exp_rd[i]);
    end
    wait_status(0, 1'b0, "R6 read ends");
    reg_read(3'd4, s); chk("R6 rxv cleared and done", s, 8'h0A);
    chk("R7 ack slots", mack_log.size(), 3);
    if (mack_log.size() == 3) begin
      chk("R7 ack byte0", mack_log[0], 0);
      chk("R7 ack byte1", mack_log[1], 0);
      chk("R7 nack last", mack_log[2], 1);
    end
    chk("R11 single start", starts - st0, 1);
    chk("R11 scoreboard drained", exp_q.size(), 0);
    reg_read(3'd1, s); chk("R11 address kept", s, 8'hA1);
    reg_write(3'd4, 8'h02);

    // R8: address not acknowledged
    reg_write(3'd0, 8'h80);
    expect_byte(8'h44);
    reg_write(3'd2, 8'h77);
    reg_write(3'd1, 8'h44);
    wait_status(0, 1'b0, "R8 nack ends");
    reg_read(3'd4, s); chk("R8 nack status", s, 8'h06);
    chk("R8 no data sent", exp_q.size(), 0);
    reg_write(3'd4, 8'h06);
    reg_read(3'd4, s); chk("R9 w1c both", s, 8'h00);

    // R2: disable during a transfer
    reg_write(3'd1, 8'hA0);
    repeat (40) @(negedge clk);
    reg_write(3'd0, 8'h00);
    @(negedge clk); @(negedge clk);
    chk("R2 abort scl released", scl_oe, 0);
    chk("R2 abort sda released", sda_oe, 0);
    reg_read(3'd4, s); chk("R2 abort not busy", s[0], 0);

    report();
  end
endmodule